// File: doc/BRIEF.md
# Extension Interface Logical-Unit Resolver

This block resolves a portable extension-interface name into a short, machine-local logical unit number. Software places a 20-bit interface identifier and a 12-bit device sequence number in one source word. It supplies a second word carrying payload bits, together with the current privilege level as a one-hot code. The block compares the identifier and device pair against a small associative table. Each table entry also holds a mask of the privilege levels allowed to use it. The block returns a result word with the logical unit in the low field and the payload above it.

A miss, a privilege denial or an illegal privilege code does not trap. It returns logical unit 0, and software tests for that value. A configuration write port fills the table at boot. After reset the table already holds two built-in fallback interfaces, return-zero and return-minus-one, usable from every privilege level. The lookup is combinational. The result is registered and flagged by a valid strobe one cycle after the request.

Top module: `lun_resolver`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle after a cycle with `req_vld` high. While no request is made, `rsp_word` keeps its previous value.
- R2: `rsp_word[31:12]` equals `req_data[19:0]` of the request. Bits `req_data[31:20]` are discarded.
- R3: An entry matches only if it is valid, its identifier equals `req_sel[31:12]` and its device number equals `req_sel[11:0]`.
- R4: A matching entry is used only when its privilege mask has the bit of `req_priv` set. The privilege codes are user=0001, supervisor=0010, hypervisor=0100 and machine=1000.
- R5: When no entry passes both R3 and R4, `rsp_word[11:0]` is 0 and no other indication is given.
- R6: When `req_priv` is not one-hot, the logical unit returned is 0.
- R7: When several entries pass, the logical unit of the lowest-index entry is returned.
- R8: After reset, entry 0 holds identifier 0x00001, device 0, mask 1111 and unit 1 (return-zero). Entry 1 holds identifier 0x00002, device 0, mask 1111 and unit 2 (return-minus-one). All other entries are invalid.
- R9: A write with `cfg_we` high replaces the entry at `cfg_idx`. Lookups from the next cycle on see the new contents, and a lookup in the same cycle sees the old contents. Writing `cfg_valid`=0 removes the entry.
- R10: During and right after reset, `rsp_vld` is 0 and `rsp_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write enable |
| cfg_idx | input | 4 | Entry index to write |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_ifid | input | 20 | Interface identifier of the entry |
| cfg_dev | input | 12 | Device sequence number of the entry |
| cfg_privmask | input | 4 | Allowed-privilege mask of the entry |
| cfg_lun | input | 12 | Logical unit number of the entry |
| req_vld | input | 1 | Lookup request strobe |
| req_sel | input | 32 | Identifier [31:12] and device [11:0] |
| req_data | input | 32 | Payload source, low 20 bits kept |
| req_priv | input | 4 | Current privilege, one-hot |
| rsp_vld | output | 1 | Result valid, one cycle after request |
| rsp_word | output | 32 | Payload [31:12], logical unit [11:0] |

## Verification
The hardest cases to reach are those where more than one entry has the same identifier and device number but a different privilege mask. Here the lowest-index rule and the privilege gate interact. A plain fill of the table never creates such pairs. The bench fills all sixteen entries so that the masks cover every pattern from 0000 to 1111. It then sweeps every entry against every 4-bit privilege code, including the non-one-hot codes, and adds deliberately duplicated keys with different masks. A write and a lookup in the same cycle are also issued, to exercise the old-contents rule.

// File: rtl/lun_resolver.sv
module lun_resolver #(
  parameter int ENTRIES = 16,
  parameter int ID_W    = 20,
  parameter int DEV_W   = 12,
  parameter int LUN_W   = 12,
  parameter int PRIV_W  = 4,
  parameter logic [ID_W-1:0] RET0_ID  = 20'h00001,
  parameter logic [ID_W-1:0] RETM1_ID = 20'h00002,
  localparam int XLEN  = ID_W + DEV_W,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PAY_W = XLEN - LUN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_ifid,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [PRIV_W-1:0] cfg_privmask,
  input  logic [LUN_W-1:0]  cfg_lun,
  input  logic              req_vld,
  input  logic [XLEN-1:0]   req_sel,
  input  logic [XLEN-1:0]   req_data,
  input  logic [PRIV_W-1:0] req_priv,
  output logic              rsp_vld,
  output logic [XLEN-1:0]   rsp_word
);

  logic              tv    [ENTRIES];
  logic [ID_W-1:0]   tid   [ENTRIES];
  logic [DEV_W-1:0]  tdev  [ENTRIES];
  logic [PRIV_W-1:0] tmask [ENTRIES];
  logic [LUN_W-1:0]  tlun  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tv[i]    <= 1'b0;
        tid[i]   <= '0;
        tdev[i]  <= '0;
        tmask[i] <= '0;
        tlun[i]  <= '0;
      end
      tv[0]    <= 1'b1;
      tid[0]   <= RET0_ID;
      tmask[0] <= '1;
      tlun[0]  <= LUN_W'(1);
      tv[1]    <= 1'b1;
      tid[1]   <= RETM1_ID;
      tmask[1] <= '1;
      tlun[1]  <= LUN_W'(2);
    end else if (cfg_we) begin
      tv[cfg_idx]    <= cfg_valid;
      tid[cfg_idx]   <= cfg_ifid;
      tdev[cfg_idx]  <= cfg_dev;
      tmask[cfg_idx] <= cfg_privmask;
      tlun[cfg_idx]  <= cfg_lun;
    end
  end

  logic [ENTRIES-1:0] hit;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = tv[g] && (tid[g] == req_sel[XLEN-1:DEV_W])
                    && (tdev[g] == req_sel[DEV_W-1:0])
                    && |(tmask[g] & req_priv);
  end

  logic [LUN_W-1:0] found_lun;
  always_comb begin
    found_lun = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (hit[i]) found_lun = tlun[i];
    if (!$onehot(req_priv)) found_lun = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_word <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) rsp_word <= {req_data[PAY_W-1:0], found_lun};
    end
  end

  logic unused_hi;
  assign unused_hi = ^req_data[XLEN-1:PAY_W];

endmodule

// File: rtl/lun_resolver_chk.sv
module lun_resolver_chk #(
  parameter int ID_W   = 20,
  parameter int DEV_W  = 12,
  parameter int LUN_W  = 12,
  parameter int PRIV_W = 4,
  localparam int XLEN  = ID_W + DEV_W,
  localparam int PAY_W = XLEN - LUN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [XLEN-1:0]   req_data,
  input logic [PRIV_W-1:0] req_priv,
  input logic              rsp_vld,
  input logic [XLEN-1:0]   rsp_word
);

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= seen_rst | !rst_n;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld); // R1
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(rsp_word)); // R1
  AST_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_word[XLEN-1:LUN_W] == $past(req_data[PAY_W-1:0])); // R2
  AST_BAD_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !$onehot(req_priv)) |=> rsp_word[LUN_W-1:0] == '0); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    (seen_rst && $past(!rst_n)) |-> (!rsp_vld && rsp_word == '0)); // R10

endmodule

bind lun_resolver lun_resolver_chk #(.ID_W(ID_W), .DEV_W(DEV_W), .LUN_W(LUN_W), .PRIV_W(PRIV_W)) u_chk (.*);

// File: tb/lun_resolver_bench.sv
module lun_resolver_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0, cfg_valid = 0;
  logic [3:0]  cfg_idx = 0, cfg_privmask = 0, req_priv = 0;
  logic [19:0] cfg_ifid = 0;
  logic [11:0] cfg_dev = 0, cfg_lun = 0;
  logic        req_vld = 0;
  logic [31:0] req_sel = 0, req_data = 0;
  logic        rsp_vld;
  logic [31:0] rsp_word;

  int errors = 0, checks = 0;

  lun_resolver u_lun_resolver (.*);

  always #5 clk = ~clk;

  logic        m_v [16];
  logic [19:0] m_id [16];
  logic [11:0] m_dev [16];
  logic [3:0]  m_mask [16];
  logic [11:0] m_lun [16];

  function automatic logic [11:0] model(logic [31:0] sel, logic [3:0] pr);
    if (!$onehot(pr)) return 12'd0;
    for (int i = 0; i < 16; i++)
      if (m_v[i] && m_id[i] == sel[31:12] && m_dev[i] == sel[11:0] && (m_mask[i] & pr) != 0)
        return m_lun[i];
    return 12'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic v, logic [19:0] id, logic [11:0] dv, logic [3:0] mk, logic [11:0] ln);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_valid = v; cfg_ifid = id;
    cfg_dev = dv; cfg_privmask = mk; cfg_lun = ln;
    @(negedge clk);
    cfg_we = 0;
    m_v[idx] = v; m_id[idx] = id; m_dev[idx] = dv; m_mask[idx] = mk; m_lun[idx] = ln;
  endtask

  task automatic look(string req, logic [31:0] sel, logic [31:0] dat, logic [3:0] pr);
    logic [31:0] exp;
    exp = {dat[19:0], model(sel, pr)};
    @(negedge clk);
    req_vld = 1; req_sel = sel; req_data = dat; req_priv = pr;
    @(negedge clk);
    req_vld = 0;
    check({req, " R1 valid"}, {31'd0, rsp_vld}, 32'd1);
    check(req, rsp_word, exp);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_id[i] = 0; m_dev[i] = 0; m_mask[i] = 0; m_lun[i] = 0;
    end
    m_v[0] = 1; m_id[0] = 20'h00001; m_mask[0] = 4'hF; m_lun[0] = 12'd1;
    m_v[1] = 1; m_id[1] = 20'h00002; m_mask[1] = 4'hF; m_lun[1] = 12'd2;
    repeat (3) @(negedge clk);
    check("R10 rsp_vld in reset", {31'd0, rsp_vld}, 32'd0);
    check("R10 rsp_word in reset", rsp_word, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R10 rsp_vld after reset", {31'd0, rsp_vld}, 32'd0);

    // R8 fallbacks over every privilege code (R6 for non-one-hot)
    for (int p = 0; p < 16; p++) begin
      look("R8 ret0", {20'h00001, 12'd0}, 32'hFFF12345 + p, 4'(p));
      look("R8 retm1", {20'h00002, 12'd0}, 32'h0ABCDE00 ^ p, 4'(p));
      look("R3 device mismatch", {20'h00001, 12'd1}, 32'h5, 4'(p));
    end

    // R1 hold: idle cycle keeps the word
    begin
      logic [31:0] held;
      held = rsp_word;
      @(negedge clk);
      check("R1 no strobe when idle", {31'd0, rsp_vld}, 32'd0);
      check("R1 word held", rsp_word, held);
    end

    // R9 fill table, then R3/R4/R5/R6 sweep
    for (int i = 0; i < 16; i++)
      wr(i, 1, 20'hA0000 + 20'(i), 12'(i * 3), 4'(i), 12'(32 + i));
    for (int i = 0; i < 16; i++)
      for (int p = 0; p < 16; p++)
        look("R4 priv sweep", {20'hA0000 + 20'(i), 12'(i * 3)}, (i * 32'h01010101) ^ (p << 20) ^ p, 4'(p));
    look("R3 id mismatch", {20'hA0001, 12'd0}, 32'h0, 4'b0001);
    look("R5 unknown", {20'hBEEF0, 12'd7}, 32'h77, 4'b1000);

    // R7 duplicated keys
    wr(4, 1, 20'hC0DE0, 12'h055, 4'b0100, 12'd36);
    wr(9, 1, 20'hC0DE0, 12'h055, 4'b1111, 12'd99);
    for (int p = 0; p < 16; p++)
      look("R7 lowest index", {20'hC0DE0, 12'h055}, 32'h1234 + p, 4'(p));

    // R9 invalidate
    wr(5, 0, 20'hA0005, 12'd15, 4'hF, 12'd37);
    look("R9 invalidated", {20'hA0005, 12'd15}, 32'h9, 4'b0010);

    // R9 same-cycle write and lookup sees old contents
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'd6; cfg_valid = 1; cfg_ifid = 20'hA0006;
    cfg_dev = 12'd18; cfg_privmask = 4'hF; cfg_lun = 12'd200;
    req_vld = 1; req_sel = {20'hA0006, 12'd18}; req_data = 32'h3; req_priv = 4'b0001;
    @(negedge clk);
    cfg_we = 0; req_vld = 0;
    check("R9 same-cycle old contents", rsp_word, {20'h3, 12'd0});
    m_v[6] = 1; m_mask[6] = 4'hF; m_lun[6] = 12'd200;
    look("R9 new contents next", {20'hA0006, 12'd18}, 32'h4, 4'b0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule